// File: doc/BRIEF.md
# Network Controller Interrupt Status, Mask and Acknowledge Registers

This block gathers the interrupt causes of a network controller into one 8-bit status register, qualifies them with an 8-bit enable register and drives one active-high interrupt line to the host. Six causes are events: single-cycle pulses from the receive path, the transmit path, the buffer allocator, the overrun detector, the PHY status logic and the early-receive logic. Each event is latched until the host clears it. The other two causes are levels: the transmit FIFO is empty, and the transmit engine is idle. These two bits are registered copies of their conditions and cannot be cleared by software.

The host reaches the block through a byte-wide register port. One offset serves two purposes. A read there returns the status. A write there is an acknowledge, where each 1 bit clears the matching latched cause. The enable register sits at the next offset and can be read and written. The transmit-idle cause is set whenever the transmit engine is not running, even if frames are still queued in the transmit FIFO. This lets a driver stop the transmitter, wait for the frame in progress to finish, and then put a new frame at the head of the queue.

Top module: `nic_irq_regs`

## Requirements
- R1: Status bit map: bit0 receive, bit1 transmit, bit2 transmit FIFO empty (level), bit3 allocation, bit4 receive overrun, bit5 PHY status, bit6 early receive, bit7 transmit idle (level). A one-cycle pulse on an event input sets its bit, and a read shows the bit from the cycle after the pulse.
- R2: A read at offset 0xC returns the status. Writes at offset 0xC never change the enable register.
- R3: The enable register is read and written at offset 0xD and resets to 0x00. Writes at offset 0xD never change the status.
- R4: `irq` is high exactly when some status bit and its enable bit are both 1.
- R5: Writing 1 to a bit at offset 0xC clears that latched status bit in the next cycle. Writing 0 to a bit leaves it unchanged.
- R6: An event pulse in the same cycle as an acknowledge of its bit leaves the bit set.
- R7: Bits 2 and 7 show their conditions one cycle later. An acknowledge does not affect them.
- R8: Bit 7 is 1 whenever `tx_busy` is low, whatever the state of `tx_fifo_empty`.
- R9: During reset, the status is 0x00 and `irq` is low. Reads at any offset other than 0xC and 0xD return 0x00. Writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ev_rx | input | 1 | Receive-complete pulse |
| ev_tx | input | 1 | Transmit-complete pulse |
| ev_alloc | input | 1 | Allocation-done pulse |
| ev_rx_ovr | input | 1 | Receive-overrun pulse |
| ev_phy | input | 1 | PHY status-change pulse |
| ev_early_rx | input | 1 | Early-receive pulse |
| tx_fifo_empty | input | 1 | Level: transmit FIFO holds no entries |
| tx_busy | input | 1 | Level: transmit engine is active |
| irq | output | 1 | Interrupt request to the host |

## Verification
The hardest case to produce from the ports is an event pulse that lands in the same cycle as an acknowledge of the same bit, because the pulse and the host write must both arrive at one clock edge. The stimulus table holds rows that drive the allocation pulse and an acknowledge of bit 3 together, and the same row also checks that the bit stays set. A second hard case is transmit-idle while the FIFO is not empty. Rows hold `tx_busy` and `tx_fifo_empty` low together and then acknowledge bit 7. This shows that the level bit survives the clear.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int NSRC = 8;

  localparam int B_RX     = 0;
  localparam int B_TX     = 1;
  localparam int B_TXEMP  = 2;
  localparam int B_ALLOC  = 3;
  localparam int B_OVR    = 4;
  localparam int B_PHY    = 5;
  localparam int B_ERX    = 6;
  localparam int B_TXIDLE = 7;

  // 1 = latched event bit, 0 = level bit
  localparam logic [NSRC-1:0] LATCH_MAP = 8'b0111_1011;

  typedef logic [NSRC-1:0] src_vec_t;

  function automatic src_vec_t pack_sources(
    input logic rx, input logic tx, input logic txemp, input logic alloc,
    input logic ovr, input logic phy, input logic erx, input logic busy);
    src_vec_t v;
    v           = '0;
    v[B_RX]     = rx;
    v[B_TX]     = tx;
    v[B_TXEMP]  = txemp;
    v[B_ALLOC]  = alloc;
    v[B_OVR]    = ovr;
    v[B_PHY]    = phy;
    v[B_ERX]    = erx;
    v[B_TXIDLE] = ~busy;
    return v;
  endfunction

  function automatic logic any_enabled(input src_vec_t stat, input src_vec_t en);
    return |(stat & en);
  endfunction
endpackage

// File: rtl/nic_irq_decode.sv
module nic_irq_decode
  import nic_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STAT_OFS = 4'hC,
  parameter logic [ADDR_W-1:0] MASK_OFS = 4'hD
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  src_vec_t          wdata,
  input  src_vec_t          stat,
  input  src_vec_t          mask,
  output src_vec_t          ack_vec,
  output logic              mask_wr,
  output src_vec_t          rdata
);
  logic hit_stat, hit_mask;
  assign hit_stat = (addr == STAT_OFS);
  assign hit_mask = (addr == MASK_OFS);

  assign ack_vec = (wr && hit_stat) ? wdata : '0;
  assign mask_wr = wr && hit_mask;

  always_comb begin
    rdata = '0;
    if (hit_stat)      rdata = stat;
    else if (hit_mask) rdata = mask;
  end
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
  import nic_irq_pkg::*;
#(
  parameter logic [NSRC-1:0] KIND = LATCH_MAP
) (
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t src,
  input  src_vec_t ack,
  output src_vec_t stat
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) stat[i] <= 1'b0;
      else        stat[i] <= KIND[i] ? ((stat[i] & ~ack[i]) | src[i]) : src[i];
    end
  end
endmodule

// File: rtl/nic_irq_mask.sv
module nic_irq_mask
  import nic_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  src_vec_t din,
  output src_vec_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= din;
  end
endmodule

// File: rtl/nic_irq_regs.sv
module nic_irq_regs
  import nic_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STAT_OFS = 4'hC,
  parameter logic [ADDR_W-1:0] MASK_OFS = 4'hD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  input  logic              ev_rx,
  input  logic              ev_tx,
  input  logic              ev_alloc,
  input  logic              ev_rx_ovr,
  input  logic              ev_phy,
  input  logic              ev_early_rx,
  input  logic              tx_fifo_empty,
  input  logic              tx_busy,
  output logic              irq
);
  src_vec_t src_vec, ack_vec, stat_q, mask_q, mask_din;
  logic     mask_wr;

  assign src_vec  = pack_sources(ev_rx, ev_tx, tx_fifo_empty, ev_alloc,
                                 ev_rx_ovr, ev_phy, ev_early_rx, tx_busy);
  assign mask_din = reg_wdata;

  nic_irq_decode #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)) u_dec (
    .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata), .stat(stat_q), .mask(mask_q),
    .ack_vec(ack_vec), .mask_wr(mask_wr), .rdata(reg_rdata));

  nic_irq_status #(.KIND(LATCH_MAP)) u_stat (
    .clk(clk), .rst_n(rst_n), .src(src_vec), .ack(ack_vec), .stat(stat_q));

  nic_irq_mask u_mask (
    .clk(clk), .rst_n(rst_n), .wr(mask_wr), .din(mask_din), .q(mask_q));

  assign irq = any_enabled(stat_q, mask_q);
endmodule

// File: rtl/nic_irq_regs_chk.sv
module nic_irq_regs_chk
  import nic_irq_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input src_vec_t src_vec,
  input src_vec_t ack_vec,
  input src_vec_t stat_q,
  input src_vec_t mask_q,
  input src_vec_t mask_din,
  input logic     mask_wr,
  input logic     irq
);
  // R4
  irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & mask_q) != '0) |-> irq);
  // R4
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & mask_q) == '0) |-> !irq);
  // R1
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_vec & LATCH_MAP) != '0) |=> ((stat_q & $past(src_vec & LATCH_MAP)) == $past(src_vec & LATCH_MAP)));
  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_vec & ~src_vec & LATCH_MAP) != '0) |=> ((stat_q & $past(ack_vec & ~src_vec & LATCH_MAP)) == '0));
  // R6
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & LATCH_MAP & ~$past(src_vec)) == '0));
  // R7
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_q & ~LATCH_MAP) == ($past(src_vec) & ~LATCH_MAP)));
  // R3
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(mask_din)));
  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));
endmodule

bind nic_irq_regs nic_irq_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_vec(src_vec), .ack_vec(ack_vec), .stat_q(stat_q),
  .mask_q(mask_q), .mask_din(mask_din), .mask_wr(mask_wr), .irq(irq));

// File: tb/nic_irq_regs_test.sv
`timescale 1ns/1ps
module nic_irq_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = 4'hC;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic ev_rx = 0, ev_tx = 0, ev_alloc = 0, ev_rx_ovr = 0, ev_phy = 0, ev_early_rx = 0;
  logic tx_fifo_empty = 0, tx_busy = 1;
  logic irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] exp_mask = 8'h00;

  always #2.5 clk = ~clk;

  nic_irq_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ev_rx(ev_rx), .ev_tx(ev_tx), .ev_alloc(ev_alloc),
    .ev_rx_ovr(ev_rx_ovr), .ev_phy(ev_phy), .ev_early_rx(ev_early_rx),
    .tx_fifo_empty(tx_fifo_empty), .tx_busy(tx_busy), .irq(irq));

  // {evt[7:0], fifo_empty, busy, wr, to_mask, wdata[7:0], exp_stat[7:0], exp_irq}
  localparam int NV = 15;
  localparam logic [28:0] VEC [NV] = '{
    {8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h01, 1'b0}, // R1 rx
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 8'h01, 8'h01, 1'b1}, // R3 R4 enable rx
    {8'h0A, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h0B, 1'b1}, // R1 tx+alloc
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h01, 8'h0A, 1'b0}, // R5 ack rx
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h0A, 1'b0}, // R5 zero ack
    {8'h08, 1'b0, 1'b1, 1'b1, 1'b0, 8'h08, 8'h0A, 1'b0}, // R6 collide
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h80, 8'h8A, 1'b1}, // R8 idle, fifo not empty
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 8'h8A, 1'b1}, // R7 ack level
    {8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h0E, 1'b0}, // R7 follow
    {8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h04, 1'b0}, // R5 ack all
    {8'h70, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h74, 1'b0}, // R1 ovr phy erx
    {8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h20, 8'h74, 1'b1}, // R3 enable phy
    {8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h20, 8'h54, 1'b0}, // R5 ack phy
    {8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h54, 1'b1}, // R4 enable all
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0}  // R5 clear all
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [7:0] exp_s, input logic exp_i);
    reg_addr = 4'hC; #0.5;
    chk({req, " status"}, reg_rdata, exp_s);
    chk({req, " irq"}, {7'd0, irq}, {7'd0, exp_i});
    reg_addr = 4'hD; #0.5;
    chk({req, " mask"}, reg_rdata, exp_mask);
    reg_addr = 4'hC;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    read_chk("R9 reset", 8'h00, 1'b0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [28:0] v;
      v = VEC[k];
      ev_rx = v[21]; ev_tx = v[22]; ev_alloc = v[24];
      ev_rx_ovr = v[25]; ev_phy = v[26]; ev_early_rx = v[27];
      tx_fifo_empty = v[20]; tx_busy = v[19];
      reg_wr = v[18]; reg_addr = v[17] ? 4'hD : 4'hC; reg_wdata = v[16:9];
      @(posedge clk); #1;
      if (v[18] && v[17]) exp_mask = v[16:9];
      reg_wr = 0; {ev_rx, ev_tx, ev_alloc, ev_rx_ovr, ev_phy, ev_early_rx} = '0;
      read_chk($sformatf("R1-table row %0d R%0d", k, 1), v[8:1], v[0]);
    end

    // R9 other offsets: read 0, writes ignored
    ev_rx = 1; @(posedge clk); #1; ev_rx = 0;
    reg_addr = 4'h5; #0.5;
    chk("R9 other offset read", reg_rdata, 8'h00);
    reg_wr = 1; reg_wdata = 8'hFF; @(posedge clk); #1; reg_wr = 0;
    read_chk("R9 other offset write", 8'h01, 1'b1);

    // R2: status write leaves mask; R3: mask write leaves status
    reg_addr = 4'hC; reg_wr = 1; reg_wdata = 8'h00; @(posedge clk); #1; reg_wr = 0;
    read_chk("R2 status write keeps mask", 8'h01, 1'b1);

    // R8 idle with fifo empty too
    tx_busy = 0; tx_fifo_empty = 1; @(posedge clk); #1;
    read_chk("R8 idle empty", 8'h85, 1'b1);

    // R9 reset mid-run
    rst_n = 0; exp_mask = 8'h00; @(posedge clk); #1;
    read_chk("R9 reset again", 8'h00, 1'b0);
    rst_n = 1; tx_busy = 1; tx_fifo_empty = 0;
    @(posedge clk); #1;
    read_chk("R9 after reset", 8'h00, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule